// File: doc/BRIEF.md
# Two-Port Hardware Semaphore Flag Unit

This block holds a small bank of ownership flags that two independent ports use to coordinate access to a shared resource. Each port chooses a flag with a short address, claims it by writing a 0 on data bit 0, and gives it back by writing a 1. At any moment a flag is either free or held by exactly one port. A port learns whether its claim succeeded by reading the flag back. The read shows all zeros to the holder and all ones to everyone else.

Claims that cannot be satisfied are not lost. A refused claim is queued, and the flag passes to the waiting port at the same clock edge that records the holder's release. So the waiter sees ownership from the cycle after the release write. When both ports claim a free flag in the same cycle, a fixed tie-break chooses the winner and queues the loser. By default the left port wins.

The flag port is only active when its semaphore select is low and its chip enable is high. The other combination with both low is illegal and is ignored.

Top module: `sem_flag_unit`

## Requirements
- R1: Eight independent flags are provided; the 3-bit port address selects the flag, and an operation on one flag never changes any other flag.
- R2: A port performs a flag access only when `sel_n`=0 and `ce_n`=1. With `sel_n`=0 and `ce_n`=0 the port is ignored: no flag changes and no read data is driven. With `sel_n`=1 the port is also idle.
- R3: A write (`rw`=0) takes its value from `wdata` bit 0 alone; bits 7..1 have no effect.
- R4: Writing 0 claims the flag. The claim succeeds at that clock edge when the other port does not hold it. Repeating a claim on a flag the port already holds changes nothing.
- R5: Writing 1 releases a flag the writing port holds. A release from a port that does not hold the flag has no effect.
- R6: A read (`rw`=1, `oe_n`=0, access valid) raises `rdata_oe` in the same cycle. `rdata` is all zeros when the reading port holds the addressed flag and all ones otherwise, reflecting the state before the next clock edge.
- R7: When a port is not reading, its `rdata_oe` is 0 and its `rdata` is all ones. This includes the case `oe_n`=1.
- R8: A claim refused because the other port holds the flag stays queued. The flag is handed to the queued port at the edge that records the holder's release.
- R9: When both ports claim a free flag in the same cycle, the left port obtains it and the right claim is queued.
- R10: No flag is ever held by both ports at once.
- R11: After reset every flag is free and no claim is queued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| l_sel_n | input | 1 | Left semaphore select, active low |
| l_ce_n | input | 1 | Left chip enable, active low; must be high for a flag access |
| l_rw | input | 1 | Left direction: 1 read, 0 write |
| l_oe_n | input | 1 | Left output enable, active low |
| l_addr | input | 3 | Left flag index |
| l_wdata | input | 8 | Left write data (bit 0 used) |
| l_rdata | output | 8 | Left read data |
| l_rdata_oe | output | 1 | Left read data driven |
| r_sel_n | input | 1 | Right semaphore select, active low |
| r_ce_n | input | 1 | Right chip enable, active low; must be high for a flag access |
| r_rw | input | 1 | Right direction: 1 read, 0 write |
| r_oe_n | input | 1 | Right output enable, active low |
| r_addr | input | 3 | Right flag index |
| r_wdata | input | 8 | Right write data (bit 0 used) |
| r_rdata | output | 8 | Right read data |
| r_rdata_oe | output | 1 | Right read data driven |

## Verification
Read results are combinational. The bench applies each port's controls just after a falling edge and compares `rdata` and `rdata_oe` one nanosecond later. At that point they must match the flag state as it was before the coming rising edge. A claim, release or queued hand-off written in one cycle is therefore checked by a read in the next cycle, not earlier. The bench's reference model advances only at the rising edge, so every expected value lines up with the register stage in the design.

// File: rtl/sem_flag_pkg.sv
package sem_flag_pkg;
   // index of each port inside the two-entry vectors used by the flag cells
   typedef enum logic {PORT_L = 1'b0, PORT_R = 1'b1} port_e;
   localparam int unsigned N_PORTS = 2;
endpackage

// File: rtl/sem_port_decode.sv
module sem_port_decode
   import sem_flag_pkg::*;
#(
   parameter int unsigned ADDR_W = 3,
   parameter int unsigned DATA_W = 8,
   localparam int unsigned NUM_FLAGS = 1 << ADDR_W
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 sel_n,
   input  logic                 ce_n,
   input  logic                 rw,
   input  logic                 oe_n,
   input  logic [ADDR_W-1:0]    addr,
   input  logic [DATA_W-1:0]    wdata,
   input  logic [NUM_FLAGS-1:0] held,
   output logic [NUM_FLAGS-1:0] req_vec,
   output logic [NUM_FLAGS-1:0] rel_vec,
   output logic [DATA_W-1:0]    rdata,
   output logic                 rdata_oe
);
   logic access;
   logic wr_en;

   // legal flag access: select low, chip enable high
   assign access = !sel_n && ce_n;
   assign wr_en  = access && !rw;

   for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_dec
      logic hit;
      assign hit        = wr_en && (addr == ADDR_W'(i));
      assign req_vec[i] = hit && !wdata[0];
      assign rel_vec[i] = hit &&  wdata[0];
   end

   assign rdata_oe = access && rw && !oe_n;
   assign rdata    = (rdata_oe && held[addr]) ? '0 : '1;

   // R2: illegal select/enable pairing produces no command and no drive
   p_illegal_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!sel_n && !ce_n) |-> (req_vec == '0 && rel_vec == '0 && !rdata_oe));

   // R1: a single access touches at most one flag
   p_one_flag_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(req_vec | rel_vec));

   // R7: idle output is all ones
   p_idle_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !rdata_oe |-> (rdata == '1));
endmodule

// File: rtl/sem_flag_cell.sv
module sem_flag_cell
   import sem_flag_pkg::*;
#(
   parameter int unsigned TIE_WINNER = 0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [N_PORTS-1:0]   req,
   input  logic [N_PORTS-1:0]   rel,
   output logic [N_PORTS-1:0]   own
);
   logic [N_PORTS-1:0] own_q, own_d;
   logic [N_PORTS-1:0] pend_q, pend_d;
   logic               win;
   logic               lose;

   // tie-break variant chosen at elaboration
   if (TIE_WINNER == 0) begin : g_tie_left
      assign win = PORT_L;
   end else begin : g_tie_right
      assign win = PORT_R;
   end
   assign lose = !win;

   always_comb begin
      own_d  = own_q;
      pend_d = pend_q;
      if (own_q == '0) begin
         if (req[win]) begin
            own_d[win] = 1'b1;
            if (req[lose]) pend_d[lose] = 1'b1;
         end else if (req[lose]) begin
            own_d[lose] = 1'b1;
         end
      end else begin
         for (int unsigned h = 0; h < N_PORTS; h++) begin
            if (own_q[h[0]]) begin
               if (rel[h[0]]) begin
                  own_d[h[0]] = 1'b0;
                  if (pend_q[!h[0]] || req[!h[0]]) begin
                     own_d[!h[0]]  = 1'b1;
                     pend_d[!h[0]] = 1'b0;
                  end
               end else if (req[!h[0]]) begin
                  pend_d[!h[0]] = 1'b1;
               end
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         own_q  <= '0;
         pend_q <= '0;
      end else begin
         own_q  <= own_d;
         pend_q <= pend_d;
      end
   end

   assign own = own_q;

   p_single_owner_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(own_q) <= 1);

   p_hold_left_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (own_q[PORT_L] && !rel[PORT_L]) |=> own_q[PORT_L]);

   p_hold_right_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (own_q[PORT_R] && !rel[PORT_R]) |=> own_q[PORT_R]);

   p_handoff_to_right_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (own_q[PORT_L] && rel[PORT_L] && pend_q[PORT_R]) |=> own_q[PORT_R]);

   p_handoff_to_left_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (own_q[PORT_R] && rel[PORT_R] && pend_q[PORT_L]) |=> own_q[PORT_L]);

   p_pend_needs_holder_r8: assert property (@(posedge clk) disable iff (!rst_n)
      pend_q[PORT_R] |-> own_q[PORT_L]);

   p_tie_break_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (own_q == '0 && req == '1) |=> (own_q[win] && pend_q[lose]));
endmodule

// File: rtl/sem_flag_unit.sv
module sem_flag_unit
   import sem_flag_pkg::*;
#(
   parameter int unsigned ADDR_W     = 3,
   parameter int unsigned DATA_W     = 8,
   parameter int unsigned TIE_WINNER = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              l_sel_n,
   input  logic              l_ce_n,
   input  logic              l_rw,
   input  logic              l_oe_n,
   input  logic [ADDR_W-1:0] l_addr,
   input  logic [DATA_W-1:0] l_wdata,
   output logic [DATA_W-1:0] l_rdata,
   output logic              l_rdata_oe,
   input  logic              r_sel_n,
   input  logic              r_ce_n,
   input  logic              r_rw,
   input  logic              r_oe_n,
   input  logic [ADDR_W-1:0] r_addr,
   input  logic [DATA_W-1:0] r_wdata,
   output logic [DATA_W-1:0] r_rdata,
   output logic              r_rdata_oe
);
   localparam int unsigned NUM_FLAGS = 1 << ADDR_W;

   if (ADDR_W < 1 || ADDR_W > 6) begin : g_bad_addr
      $error("sem_flag_unit: ADDR_W must lie in 1..6");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("sem_flag_unit: DATA_W must be at least 1");
   end
   if (TIE_WINNER > 1) begin : g_bad_tie
      $error("sem_flag_unit: TIE_WINNER must be 0 or 1");
   end

   logic [NUM_FLAGS-1:0] l_req, l_rel, r_req, r_rel;
   logic [NUM_FLAGS-1:0] l_held, r_held;

   sem_port_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec_l (
      .clk(clk), .rst_n(rst_n),
      .sel_n(l_sel_n), .ce_n(l_ce_n), .rw(l_rw), .oe_n(l_oe_n),
      .addr(l_addr), .wdata(l_wdata), .held(l_held),
      .req_vec(l_req), .rel_vec(l_rel),
      .rdata(l_rdata), .rdata_oe(l_rdata_oe)
   );

   sem_port_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec_r (
      .clk(clk), .rst_n(rst_n),
      .sel_n(r_sel_n), .ce_n(r_ce_n), .rw(r_rw), .oe_n(r_oe_n),
      .addr(r_addr), .wdata(r_wdata), .held(r_held),
      .req_vec(r_req), .rel_vec(r_rel),
      .rdata(r_rdata), .rdata_oe(r_rdata_oe)
   );

   for (genvar f = 0; f < NUM_FLAGS; f++) begin : g_flag
      logic [N_PORTS-1:0] own;
      sem_flag_cell #(.TIE_WINNER(TIE_WINNER)) u_cell (
         .clk(clk), .rst_n(rst_n),
         .req({r_req[f], l_req[f]}),
         .rel({r_rel[f], l_rel[f]}),
         .own(own)
      );
      assign l_held[f] = own[PORT_L];
      assign r_held[f] = own[PORT_R];
   end

   // R10 at the unit level: the two ownership maps never overlap
   p_disjoint_maps_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (l_held & r_held) == '0);

   // R1: a write on one flag leaves flags at other addresses unchanged
   p_other_flags_stable_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (r_sel_n && !l_sel_n && l_ce_n && !l_rw)
         |=> ((l_held & ~(NUM_FLAGS'(1) << $past(l_addr)))
              == ($past(l_held) & ~(NUM_FLAGS'(1) << $past(l_addr)))));
endmodule

// File: tb/tb_sem_flag_unit.sv
`timescale 1ns/1ps
module tb_sem_flag_unit;
   typedef struct {
      logic       sel_n;
      logic       ce_n;
      logic       rw;
      logic       oe_n;
      logic [2:0] a;
      logic [7:0] d;
   } stim_t;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       l_sel_n = 1'b1, l_ce_n = 1'b1, l_rw = 1'b1, l_oe_n = 1'b1;
   logic [2:0] l_addr = '0;
   logic [7:0] l_wdata = '0;
   logic [7:0] l_rdata;
   logic       l_rdata_oe;
   logic       r_sel_n = 1'b1, r_ce_n = 1'b1, r_rw = 1'b1, r_oe_n = 1'b1;
   logic [2:0] r_addr = '0;
   logic [7:0] r_wdata = '0;
   logic [7:0] r_rdata;
   logic       r_rdata_oe;

   int checks = 0;
   int fails  = 0;
   bit m_own [2][8];
   bit m_pend[2][8];

   always #2 clk = ~clk;

   sem_flag_unit dut (
      .clk(clk), .rst_n(rst_n),
      .l_sel_n(l_sel_n), .l_ce_n(l_ce_n), .l_rw(l_rw), .l_oe_n(l_oe_n),
      .l_addr(l_addr), .l_wdata(l_wdata), .l_rdata(l_rdata), .l_rdata_oe(l_rdata_oe),
      .r_sel_n(r_sel_n), .r_ce_n(r_ce_n), .r_rw(r_rw), .r_oe_n(r_oe_n),
      .r_addr(r_addr), .r_wdata(r_wdata), .r_rdata(r_rdata), .r_rdata_oe(r_rdata_oe)
   );

   function automatic stim_t s_wr(input logic [2:0] a, input logic [7:0] d);
      stim_t s; s.sel_n = 0; s.ce_n = 1; s.rw = 0; s.oe_n = 1; s.a = a; s.d = d; return s;
   endfunction
   function automatic stim_t s_rd(input logic [2:0] a);
      stim_t s; s.sel_n = 0; s.ce_n = 1; s.rw = 1; s.oe_n = 0; s.a = a; s.d = 8'h00; return s;
   endfunction
   function automatic stim_t s_idle();
      stim_t s; s.sel_n = 1; s.ce_n = 1; s.rw = 1; s.oe_n = 1; s.a = 0; s.d = 8'h00; return s;
   endfunction

   task automatic chk(input string tag, input logic [8:0] act, input logic [8:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
      end
   endtask

   // expected read response of a port, from R6/R7
   function automatic logic [8:0] exp_read(input int p, input stim_t s);
      logic oe;
      oe = !s.sel_n && s.ce_n && s.rw && !s.oe_n;
      if (!oe) return {1'b0, 8'hFF};
      return {1'b1, m_own[p][s.a] ? 8'h00 : 8'hFF};
   endfunction

   // reference update at the clock edge, from R2..R5, R8, R9
   task automatic model_edge(input stim_t sl, input stim_t sr);
      bit rq[2][8], rl[2][8];
      stim_t st[2];
      st[0] = sl; st[1] = sr;
      for (int p = 0; p < 2; p++)
         for (int f = 0; f < 8; f++) begin
            rq[p][f] = !st[p].sel_n && st[p].ce_n && !st[p].rw && st[p].a == f && !st[p].d[0];
            rl[p][f] = !st[p].sel_n && st[p].ce_n && !st[p].rw && st[p].a == f &&  st[p].d[0];
         end
      for (int f = 0; f < 8; f++) begin
         if (!m_own[0][f] && !m_own[1][f]) begin
            if (rq[0][f]) begin m_own[0][f] = 1; m_pend[1][f] = rq[1][f]; end
            else if (rq[1][f]) m_own[1][f] = 1;
         end else begin
            int h, o;
            h = m_own[0][f] ? 0 : 1; o = 1 - h;
            if (rl[h][f]) begin
               m_own[h][f] = 0;
               if (m_pend[o][f] || rq[o][f]) begin m_own[o][f] = 1; m_pend[o][f] = 0; end
            end else if (rq[o][f]) m_pend[o][f] = 1;
         end
      end
   endtask

   task automatic step(input string tag, input stim_t sl, input stim_t sr);
      @(negedge clk);
      l_sel_n = sl.sel_n; l_ce_n = sl.ce_n; l_rw = sl.rw; l_oe_n = sl.oe_n; l_addr = sl.a; l_wdata = sl.d;
      r_sel_n = sr.sel_n; r_ce_n = sr.ce_n; r_rw = sr.rw; r_oe_n = sr.oe_n; r_addr = sr.a; r_wdata = sr.d;
      #1;
      chk({tag, " left"},  {l_rdata_oe, l_rdata}, exp_read(0, sl));
      chk({tag, " right"}, {r_rdata_oe, r_rdata}, exp_read(1, sr));
      @(posedge clk);
      model_edge(sl, sr);
   endtask

   initial begin
      #800000;
      fails++; checks++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      stim_t s;
      void'($urandom(32'd1357));
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      // R11: every flag free after reset
      for (int f = 0; f < 8; f++) step("R11 reset state", s_rd(3'(f)), s_rd(3'(f)));
      // R4: left claims flag 3; right claim refused and queued (R8)
      step("R4 claim", s_wr(3'd3, 8'h00), s_idle());
      step("R4 holder reads", s_rd(3'd3), s_rd(3'd3));
      step("R4 repeat claim", s_wr(3'd3, 8'h00), s_wr(3'd3, 8'h00));
      step("R8 queued", s_rd(3'd3), s_rd(3'd3));
      // R1: neighbouring flags untouched
      step("R1 neighbour", s_rd(3'd2), s_rd(3'd4));
      // R8: release hands the flag over
      step("R8 release", s_wr(3'd3, 8'h01), s_idle());
      step("R8 handed over", s_rd(3'd3), s_rd(3'd3));
      // R5: left release of a flag it does not hold
      step("R5 non-holder release", s_wr(3'd3, 8'hFF), s_idle());
      step("R5 still right", s_rd(3'd3), s_rd(3'd3));
      // R3: upper data bits ignored
      step("R3 claim 0xFE", s_wr(3'd5, 8'hFE), s_idle());
      step("R3 readback", s_rd(3'd5), s_rd(3'd5));
      step("R3 release 0x01", s_wr(3'd5, 8'h01), s_idle());
      step("R3 freed", s_rd(3'd5), s_rd(3'd5));
      // R2: illegal pairing and deselect are ignored
      s = s_wr(3'd6, 8'h00); s.ce_n = 0;
      step("R2 illegal write", s, s_idle());
      s = s_rd(3'd6); s.ce_n = 0;
      step("R2 illegal read", s, s_rd(3'd6));
      s = s_wr(3'd6, 8'h00); s.sel_n = 1;
      step("R2 deselected write", s_idle(), s);
      step("R2 check free", s_rd(3'd6), s_rd(3'd6));
      // R9: simultaneous claim on free flag 2, left wins
      step("R9 tie", s_wr(3'd2, 8'h00), s_wr(3'd2, 8'h00));
      step("R9 winner", s_rd(3'd2), s_rd(3'd2));
      step("R9 left release", s_wr(3'd2, 8'h01), s_idle());
      step("R9 right gets it", s_rd(3'd2), s_rd(3'd2));
      // R7: output enable high gives no drive
      s = s_rd(3'd2); s.oe_n = 1;
      step("R7 oe off", s_idle(), s);
      // R10 and all: constrained random traffic
      for (int n = 0; n < 3000; n++) begin
         stim_t sp[2];
         for (int p = 0; p < 2; p++) begin
            int k;
            k = $urandom_range(0, 15);
            sp[p].sel_n = (k == 0);
            sp[p].ce_n  = (k != 1);
            sp[p].rw    = $urandom_range(0, 1);
            sp[p].oe_n  = (k == 2);
            sp[p].a     = 3'($urandom_range(0, 3));
            sp[p].d     = 8'($urandom);
         end
         step("R10 random", sp[0], sp[1]);
      end
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule